// File: doc/BRIEF.md
# Two-Group Thread Issue Picker

This block chooses, every clock, which hardware threads of an eight-thread core are sent to the core's two execution pipes. The threads are split into two fixed groups of four. Threads 0 to 3 form group 0, which feeds pipe 0. Threads 4 to 7 form group 1, which feeds pipe 1. A thread never changes group.

Each group has its own picker. The picker keeps an age list of its four threads and offers the oldest thread that is ready. A thread that is not ready, for example because it waits on memory, is skipped. A thread moves to the youngest position only when its instruction really issues.

The core has a single load/store unit, so the two offers are checked against each other. If both are loads, one group yields for that cycle. Its load is kept pending and issues first on the next cycle, without a fresh pick. The issue outputs carry only a valid flag and give the pipes no means to push back. An instruction that is presented with valid high counts as issued in that cycle.

Top module: `thread_pick_pair`

## Requirements
- R1: Pipe 0 only ever issues thread ids 0..3 and pipe 1 only ids 4..7; `pipe_tid` carries the global 3-bit thread id, pipe 0 in bits [2:0] and pipe 1 in bits [5:3].
- R2: `pipe_load[g]` is high exactly when pipe g issues a load. For a fresh pick it follows `thr_load` of the issued thread. For a held load it is always 1.
- R3: A fresh pick is the ready thread of the group that issued least recently. After reset the age order is ascending thread index, lowest oldest. Only an actual issue makes a thread the most recent.
- R4: A thread whose `thr_ready` bit is low is never freshly picked, even when it is the oldest.
- R5: With no held load and no ready thread in a group, that pipe's valid is low for the cycle.
- R6: With all eight threads ready and no loads, each thread issues exactly once in every four consecutive cycles, in ascending order within its group.
- R7: Two loads never issue in the same cycle.
- R8: When two fresh loads collide, the yielding group alternates between collisions, starting with group 0 after reset.
- R9: A load that yielded issues on the next cycle on its own pipe, whatever `thr_ready` shows then. It issues before any new pick of that group, and the group's age order is left unchanged while it waits.
- R10: A held load always wins over a fresh load from the other group. That other group yields instead, and this does not advance the alternation of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_ready | input | 8 | Per-thread eligible flag, bit = thread id |
| thr_load | input | 8 | Per-thread "next instruction is a load" flag |
| pipe_valid | output | 2 | Bit g: pipe g issues this cycle |
| pipe_tid | output | 6 | Issued thread ids, pipe g in bits [3g+2:3g] |
| pipe_load | output | 2 | Bit g: the instruction issued on pipe g is a load |

## Verification
The issue outputs are combinational from the inputs and the registered age lists, pending loads and alternation bit. Every decision is therefore due in the same cycle as the flags that cause it. State changes, such as age order, a held load or the alternation bit, show up from the following cycle on. The bench drives flags on the falling edge and compares all outputs one nanosecond later against a queue-based model. It then advances the model once, which stands for the next rising edge. A held load is therefore checked exactly one cycle after its collision.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int NGRP = 2;
  typedef enum logic {YIELD_G0 = 1'b0, YIELD_G1 = 1'b1} yield_e;
endpackage

// File: rtl/tp_lru_group.sv
module tp_lru_group #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ready,
  input  logic          upd,
  input  logic [IW-1:0] upd_idx,
  output logic          pick_valid,
  output logic [IW-1:0] pick_idx
);
  // age[0] is the oldest thread, age[N-1] the most recent
  logic [IW-1:0] age [N];
  logic [IW-1:0] age_nxt [N];
  logic [IW-1:0] pos;

  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ready[age[i]]) begin
        pick_valid = 1'b1;
        pick_idx   = age[i];
      end
    end
  end

  always_comb begin
    pos = '0;
    for (int i = 0; i < N; i++) begin
      if (age[i] == upd_idx) pos = IW'(i);
    end
    for (int i = 0; i < N - 1; i++) begin
      age_nxt[i] = (i >= int'(pos)) ? age[i + 1] : age[i];
    end
    age_nxt[N-1] = upd_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (upd) begin
      for (int i = 0; i < N; i++) age[i] <= age_nxt[i];
    end
  end
endmodule

// File: rtl/tp_load_arb.sv
module tp_load_arb
  import tp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] cand_v,
  input  logic [NGRP-1:0] cand_ld,
  input  logic [NGRP-1:0] pend,
  output logic [NGRP-1:0] grant
);
  yield_e tog;
  logic   clash;

  always_comb begin
    clash = (&cand_v) & (&cand_ld);
    grant = cand_v;
    if (clash) begin
      if (pend[0])      grant[1] = 1'b0;
      else if (pend[1]) grant[0] = 1'b0;
      else              grant[tog] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tog <= YIELD_G0;
    else if (clash && !(|pend)) tog <= (tog == YIELD_G0) ? YIELD_G1 : YIELD_G0;
  end
endmodule

// File: rtl/thread_pick_pair.sv
module thread_pick_pair
  import tp_pkg::*;
#(
  parameter int GS = 4,
  localparam int NT = NGRP * GS,
  localparam int TW = $clog2(NT),
  localparam int IW = $clog2(GS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NT-1:0]      thr_ready,
  input  logic [NT-1:0]      thr_load,
  output logic [NGRP-1:0]    pipe_valid,
  output logic [NGRP*TW-1:0] pipe_tid,
  output logic [NGRP-1:0]    pipe_load
);
  logic [NGRP-1:0] cand_v, cand_ld, pend, grant, pick_v;
  logic [IW-1:0]   cand_idx [NGRP];
  logic [IW-1:0]   pick_idx [NGRP];
  logic [IW-1:0]   pend_idx [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GS-1:0] grp_ld;
    assign grp_ld = thr_load[g*GS +: GS];

    tp_lru_group #(.N(GS), .IW(IW)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .ready      (thr_ready[g*GS +: GS]),
      .upd        (grant[g]),
      .upd_idx    (cand_idx[g]),
      .pick_valid (pick_v[g]),
      .pick_idx   (pick_idx[g])
    );

    always_comb begin
      cand_v[g]   = pend[g] | pick_v[g];
      cand_idx[g] = pend[g] ? pend_idx[g] : pick_idx[g];
      cand_ld[g]  = pend[g] | grp_ld[cand_idx[g]];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g]     <= 1'b0;
        pend_idx[g] <= '0;
      end else if (grant[g]) begin
        pend[g]     <= 1'b0;
      end else if (cand_v[g]) begin
        pend[g]     <= 1'b1;
        pend_idx[g] <= cand_idx[g];
      end
    end

    assign pipe_valid[g]           = grant[g];
    assign pipe_load[g]            = grant[g] & cand_ld[g];
    assign pipe_tid[g*TW +: TW]    = TW'(g * GS) + TW'(cand_idx[g]);
  end

  tp_load_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand_v  (cand_v),
    .cand_ld (cand_ld),
    .pend    (pend),
    .grant   (grant)
  );
endmodule

// File: rtl/tp_checker.sv
module tp_checker
  import tp_pkg::*;
#(
  parameter int GS = 4,
  parameter int TW = 3,
  parameter int IW = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NGRP*GS-1:0] thr_ready,
  input logic [NGRP-1:0]    pipe_valid,
  input logic [NGRP*TW-1:0] pipe_tid,
  input logic [NGRP-1:0]    pipe_load,
  input logic [NGRP-1:0]    cand_v,
  input logic [IW-1:0]      cand_idx [NGRP],
  input logic [NGRP-1:0]    pend
);
  AST_PIPE0_OWN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_valid[0] |-> (int'(pipe_tid[TW-1:0]) < GS)); // R1
  AST_PIPE1_OWN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_valid[1] |-> (int'(pipe_tid[2*TW-1:TW]) >= GS)); // R1
  AST_SINGLE_LSU: assert property (@(posedge clk) disable iff (!rst_n)
    !(pipe_valid[0] && pipe_load[0] && pipe_valid[1] && pipe_load[1])); // R7
  AST_IDLE_G0: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend[0] && !(|thr_ready[GS-1:0])) |-> !pipe_valid[0]); // R5
  AST_HELD_G0: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_v[0] && !pipe_valid[0]) |=>
      (pipe_valid[0] && pipe_load[0] && pipe_tid[TW-1:0] == TW'($past(cand_idx[0])))); // R9
  AST_HELD_G1: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_v[1] && !pipe_valid[1]) |=>
      (pipe_valid[1] && pipe_load[1] && pipe_tid[2*TW-1:TW] == TW'(GS) + TW'($past(cand_idx[1])))); // R9
endmodule

bind thread_pick_pair tp_checker #(.GS(GS), .TW(TW), .IW(IW)) u_tp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .thr_ready  (thr_ready),
  .pipe_valid (pipe_valid),
  .pipe_tid   (pipe_tid),
  .pipe_load  (pipe_load),
  .cand_v     (cand_v),
  .cand_idx   (cand_idx),
  .pend       (pend)
);

// File: tb/test_thread_pick_pair.sv
module test_thread_pick_pair;
  localparam int GS = 4;
  localparam int TW = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rdy, ld;
  logic [1:0] pv, pl;
  logic [5:0] pt;

  always #2 clk = ~clk;

  thread_pick_pair i_thread_pick_pair (
    .clk(clk), .rst_n(rst_n), .thr_ready(rdy), .thr_load(ld),
    .pipe_valid(pv), .pipe_tid(pt), .pipe_load(pl)
  );

  int    n_chk = 0, n_err = 0;
  int    ord [2][$];
  bit    mp [2];
  int    mpi [2];
  bit    tog;
  string phase_tag = "";
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int g = 0; g < 2; g++) begin
      ord[g].delete();
      for (int i = 0; i < GS; i++) ord[g].push_back(i);
      mp[g] = 0;
      mpi[g] = 0;
    end
    tog = 0;
  endtask

  task automatic step();
    bit cv [2], cl [2], gr [2], skp [2];
    int ci [2];
    bit clash, anyp;
    for (int g = 0; g < 2; g++) begin
      cv[g] = 0; cl[g] = 0; ci[g] = 0; skp[g] = 0;
      if (mp[g]) begin
        cv[g] = 1; ci[g] = mpi[g]; cl[g] = 1;
      end else begin
        for (int k = 0; k < ord[g].size(); k++) begin
          if (!cv[g]) begin
            if (rdy[g*GS + ord[g][k]]) begin
              cv[g] = 1; ci[g] = ord[g][k]; cl[g] = ld[g*GS + ord[g][k]];
            end else skp[g] = 1;
          end
        end
      end
    end
    clash = cv[0] && cv[1] && cl[0] && cl[1];
    anyp  = mp[0] || mp[1];
    gr[0] = cv[0]; gr[1] = cv[1];
    if (clash) begin
      if (mp[0])      gr[1] = 0;
      else if (mp[1]) gr[0] = 0;
      else            gr[tog] = 0;
    end
    for (int g = 0; g < 2; g++) begin
      string t;
      if (phase_tag != "")       t = phase_tag;
      else if (clash && anyp)    t = "R10";
      else if (clash)            t = "R8";
      else if (mp[g])            t = "R9";
      else if (!cv[g])           t = "R5";
      else if (skp[g])           t = "R4";
      else                       t = "R3";
      chk(pv[g] == gr[g], t, $sformatf("pipe%0d valid", g), pv[g], gr[g]);
      if (gr[g]) begin
        chk(int'(pt[g*TW +: TW]) == g*GS + ci[g], t, $sformatf("pipe%0d tid", g),
            pt[g*TW +: TW], g*GS + ci[g]);
        chk(pl[g] == cl[g], "R2", $sformatf("pipe%0d load", g), pl[g], cl[g]);
      end
      if (pv[g])
        chk(int'(pt[g*TW +: TW]) / GS == g, "R1", $sformatf("pipe%0d group", g),
            int'(pt[g*TW +: TW]) / GS, g);
    end
    chk(!(pv[0] && pl[0] && pv[1] && pl[1]), "R7", "dual load issue", 2, 1);
    for (int g = 0; g < 2; g++) begin
      if (gr[g]) begin
        for (int k = 0; k < ord[g].size(); k++)
          if (ord[g][k] == ci[g]) begin ord[g].delete(k); break; end
        ord[g].push_back(ci[g]);
        mp[g] = 0;
      end else if (cv[g]) begin
        mp[g] = 1; mpi[g] = ci[g];
      end
    end
    if (clash && !anyp) tog = ~tog;
  endtask

  task automatic cyc(logic [7:0] r, logic [7:0] l);
    @(negedge clk);
    rdy = r; ld = l;
    #1;
    step();
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; rdy = '0; ld = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R6: reset order then fair rotation, all ready, no loads
    phase_tag = "R6";
    for (int i = 0; i < 8; i++) cyc(8'hFF, 8'h00);
    phase_tag = "";
    // R4: oldest threads stalled
    cyc(8'b1100_0110, 8'h00);
    cyc(8'b0001_1000, 8'h00);
    // R5: one group fully idle
    cyc(8'b0000_1111, 8'h00);
    cyc(8'b0000_0000, 8'h00);
    // R8/R10/R9: load collisions
    for (int i = 0; i < 6; i++) cyc(8'hFF, 8'hFF);
    cyc(8'h00, 8'h00);
    cyc(8'hFF, 8'h0F);
    cyc(8'h00, 8'h00);
    cyc(8'hFF, 8'hFF);
    cyc(8'h00, 8'h00);
    cyc(8'hFF, 8'hFF);
    cyc(8'h0F, 8'h0F);
    cyc(8'h00, 8'h00);
    // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      logic [7:0] r, l;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr[7:0] | lfsr[15:8];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      l = lfsr[11:4];
      cyc(r, l);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule